// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

This unit adds or subtracts two signed numbers held in sign-magnitude form. Each operand has a sign bit and a `W`-bit magnitude. A one-cycle `start` pulse captures both operands and the operation. A small state machine then drives a single ripple adder. A conditional ones-complementer sits in front of that adder and is shared between the main sum and the later correction step.

Subtraction inverts the sign of the second operand, after which the flow is the same as for addition. When the effective signs agree, the unit adds the magnitudes and the carry-out becomes the overflow flag. When the signs disagree, it adds the complement of the second magnitude plus one. A carry-out of zero in that case means the first magnitude was the smaller one. The unit then spends one more cycle taking the two's complement of the partial result and inverting the sign. A difference of exactly zero always comes out with a positive sign.

The state machine has four states:
- `ST_IDLE` holds the results and waits for `start`. The transition *launch* (on `start`) goes to `ST_ADD`.
- `ST_ADD` forms the sum. From there, *settle* goes to `ST_FINISH` when no correction is needed, and *borrow* goes to `ST_NEGATE`.
- `ST_NEGATE` complements the magnitude. It always takes *fixed* to `ST_FINISH`.
- `ST_FINISH` raises `done`. It always takes *retire* back to `ST_IDLE`.

Top module: `smag_addsub`

## Requirements
- R1: During and right after an active-low synchronous reset, `res_mag` is 0, `res_sign` is 0, `ovf` is 0 and `done` is 0.
- R2: `sub_mode` = 1 selects subtraction: the effective sign of B is `b_sign_in` XOR `sub_mode`; `sub_mode` = 0 selects addition.
- R3: When A's sign and B's effective sign differ, `ovf` is 0 at `done`.
- R4: When A's sign equals B's effective sign, at `done` `res_mag` = (A+B) mod 2^W, `ovf` = 1 exactly when A+B ≥ 2^W, and `res_sign` equals A's sign.
- R5: When the signs differ and A ≥ B, `res_mag` = A−B and `res_sign` is A's sign, except that a zero result has `res_sign` = 0.
- R6: When the signs differ and A < B, `res_mag` = B−A and `res_sign` is the inverse of A's sign.
- R7: `done` is high for exactly one cycle per accepted `start`. It rises 2 clock edges after the edge that samples `start`, or 3 edges when the R6 correction applies.
- R8: A `start` seen while an operation is in flight is ignored. While idle without `start`, `res_mag`, `res_sign` and `ovf` hold their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to capture operands and begin |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| a_sign_in | input | 1 | Sign of operand A (1 = negative) |
| a_mag_in | input | W | Magnitude of operand A |
| b_sign_in | input | 1 | Sign of operand B (1 = negative) |
| b_mag_in | input | W | Magnitude of operand B |
| res_sign | output | 1 | Result sign (the A sign register) |
| res_mag | output | W | Result magnitude (the A magnitude register) |
| ovf | output | 1 | Magnitude overflow flag |
| done | output | 1 | One-cycle strobe marking a valid result |

## Verification
A stuck or misrouted complement enable shows up on the very next `done` for any operand pair with differing signs. The magnitude comes out as A+B instead of |A−B|. A wrong state transition shows up either as a `done` at the wrong edge count, or as a result whose sign was never inverted when A < B. Each of these is visible within three cycles of the `start` that exposes it. A lost zero-sign fix appears only when the magnitudes are equal, so the bench steers directed cases there. A result register that is not held while idle shows as drifting outputs in the cycles after `done`.

// File: rtl/smag_pkg.sv
package smag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADD    = 2'd1,
        ST_NEGATE = 2'd2,
        ST_FINISH = 2'd3
    } smag_state_t;
endpackage

// File: rtl/smag_cmpl.sv
module smag_cmpl #(
    parameter int W = 4
) (
    input  logic         inv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[i] ^ inv;
    end
endmodule

// File: rtl/smag_adder.sv
module smag_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;
    assign carry[0] = cin;
    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]     = x[i] ^ y[i] ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
    end
    assign cout = carry[W];
endmodule

// File: rtl/smag_addsub.sv
module smag_addsub
    import smag_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sub_mode,
    input  logic         a_sign_in,
    input  logic [W-1:0] a_mag_in,
    input  logic         b_sign_in,
    input  logic [W-1:0] b_mag_in,
    output logic         res_sign,
    output logic [W-1:0] res_mag,
    output logic         ovf,
    output logic         done
);
    localparam logic [W-1:0] MAG_ZERO = '0;

    smag_state_t state, state_nx;

    logic [W-1:0] a_q, b_q;
    logic         a_s_q, b_s_eff_q, ovf_q;
    logic         diff_q;
    logic         busy;

    logic [W-1:0] add_x, add_src, add_y, add_sum;
    logic         add_inv, add_cout;

    // Shared datapath: the main sum, or ~A + 1 while correcting
    always_comb begin
        if (state == ST_NEGATE) begin
            add_x   = MAG_ZERO;
            add_src = a_q;
            add_inv = 1'b1;
        end else begin
            add_x   = a_q;
            add_src = b_q;
            add_inv = diff_q;
        end
    end

    smag_cmpl #(.W(W)) u_cmpl (
        .inv  (add_inv),
        .din  (add_src),
        .dout (add_y)
    );

    smag_adder #(.W(W)) u_adder (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_inv),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ADD;                       // launch
            ST_ADD:    state_nx = (diff_q && !add_cout) ? ST_NEGATE       // borrow
                                                        : ST_FINISH;       // settle
            ST_NEGATE: state_nx = ST_FINISH;                               // fixed
            ST_FINISH: state_nx = ST_IDLE;                                 // retire
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Operand and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q       <= '0;
            b_q       <= '0;
            a_s_q     <= 1'b0;
            b_s_eff_q <= 1'b0;
            ovf_q     <= 1'b0;
            diff_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_q       <= a_mag_in;
                        b_q       <= b_mag_in;
                        a_s_q     <= a_sign_in;
                        b_s_eff_q <= b_sign_in ^ sub_mode;
                        diff_q    <= a_sign_in ^ (b_sign_in ^ sub_mode);
                    end
                end
                ST_ADD: begin
                    a_q <= add_sum;
                    if (diff_q) begin
                        ovf_q <= 1'b0;
                        if (add_cout && add_sum == MAG_ZERO) a_s_q <= 1'b0;
                    end else begin
                        ovf_q <= add_cout;
                    end
                end
                ST_NEGATE: begin
                    a_q   <= add_sum;
                    a_s_q <= ~a_s_q;
                end
                ST_FINISH: ;
            endcase
        end
    end

    // Output decode
    always_comb begin
        done     = (state == ST_FINISH);
        busy     = (state != ST_IDLE);
        res_mag  = a_q;
        res_sign = a_s_q;
        ovf      = ovf_q;
    end

endmodule

// File: rtl/smag_addsub_chk.sv
module smag_addsub_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         diff_q,
    input logic         done,
    input logic         ovf,
    input logic         res_sign,
    input logic [W-1:0] res_mag
);
    // R7: done lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: an accepted start never yields done on the next cycle
    p_start_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !done);

    // R3: no overflow when signs differ
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && diff_q) |-> !ovf);

    // R5: no negative zero from a difference
    p_no_negzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && diff_q) |-> !(res_sign && res_mag == '0));

    // R8: results hold while idle without start
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_mag) && $stable(res_sign) && $stable(ovf)));
endmodule

bind smag_addsub smag_addsub_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .diff_q   (diff_q),
    .done     (done),
    .ovf      (ovf),
    .res_sign (res_sign),
    .res_mag  (res_mag)
);

// File: tb/smag_addsub_bench.sv
module smag_addsub_bench;
    localparam int W = 4;
    localparam int CLK_PERIOD = 10;
    localparam int LIM = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sub_mode = 1'b0;
    logic         a_sign_in = 1'b0;
    logic [W-1:0] a_mag_in = '0;
    logic         b_sign_in = 1'b0;
    logic [W-1:0] b_mag_in = '0;
    logic         res_sign;
    logic [W-1:0] res_mag;
    logic         ovf;
    logic         done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smag_addsub #(.W(W)) u_smag_addsub (
        .clk(clk), .rst_n(rst_n), .start(start), .sub_mode(sub_mode),
        .a_sign_in(a_sign_in), .a_mag_in(a_mag_in),
        .b_sign_in(b_sign_in), .b_mag_in(b_mag_in),
        .res_sign(res_sign), .res_mag(res_mag), .ovf(ovf), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result from the requirements: {sign, ovf, mag, latency}
    function automatic void model(input bit as, input int a, input bit bs, input int b,
                                  input bit sub, output bit es, output bit ev,
                                  output int em, output int lat, output bit dif);
        bit be = bs ^ sub;
        dif = (as != be);
        if (!dif) begin
            em = (a + b) % LIM; ev = ((a + b) >= LIM); es = as; lat = 2;
        end else if (a >= b) begin
            em = a - b; ev = 0; es = (a == b) ? 1'b0 : as; lat = 2;
        end else begin
            em = b - a; ev = 0; es = ~as; lat = 3;
        end
    endfunction

    task automatic run_op(input bit as, input int a, input bit bs, input int b,
                          input bit sub, input bit extra_start);
        bit es, ev, dif;
        int em, lat, cyc;
        model(as, a, bs, b, sub, es, ev, em, lat, dif);
        a_sign_in = as; a_mag_in = a[W-1:0];
        b_sign_in = bs; b_mag_in = b[W-1:0];
        sub_mode = sub; start = 1'b1;
        @(negedge clk);
        cyc = 1;
        if (extra_start) begin
            a_mag_in = ~a[W-1:0]; b_mag_in = ~b[W-1:0]; sub_mode = ~sub;
        end else begin
            start = 1'b0;
        end
        while (!done && cyc < 8) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        check(lat == 3 ? "R6/R7 latency" : "R7 latency", cyc, lat);
        check(sub ? "R2 sub mag" : "R2 add mag", int'(res_mag), em);
        if (!dif)            check("R4 sign", int'(res_sign), int'(es));
        else if (a >= b)     check("R5 sign", int'(res_sign), int'(es));
        else                 check("R6 sign", int'(res_sign), int'(es));
        check(dif ? "R3 ovf" : "R4 ovf", int'(ovf), int'(ev));
        @(negedge clk);
        check("R7 done pulse", int'(done), 0);
        // R8: inputs wiggle without start, results must hold
        a_mag_in = a_mag_in + 1; b_sign_in = ~b_sign_in;
        @(negedge clk);
        check("R8 hold mag", int'(res_mag), em);
        check("R8 hold sign", int'(res_sign), int'(es));
        check("R8 hold ovf", int'(ovf), int'(ev));
        check("R8 no done", int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mag", int'(res_mag), 0);
        check("R1 sign", int'(res_sign), 0);
        check("R1 ovf", int'(ovf), 0);
        check("R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(res_mag), 0);

        // Directed corner cases
        run_op(0, 5, 1, 3, 0, 0);   // (+5)+(-3) = +2, R5
        run_op(1, 3, 1, 5, 1, 0);   // (-3)-(-5) = +2, R6
        run_op(0, 3, 0, 5, 0, 0);   // (+3)+(+5) = +8, R4
        run_op(1, 3, 0, 5, 1, 0);   // (-3)-(+5) = -8, R2
        run_op(1, 9, 1, 9, 0, 0);   // overflow, R4
        run_op(0, 15, 0, 1, 0, 0);  // carry to exact zero, R4
        run_op(1, 7, 1, 7, 1, 0);   // zero difference, R5 positive zero
        run_op(0, 6, 0, 6, 1, 0);   // zero difference, R5
        run_op(0, 0, 0, 15, 1, 0);  // R6 max borrow
        run_op(1, 2, 0, 11, 0, 1);  // R8 start while busy ignored
        run_op(0, 12, 0, 4, 1, 1);  // R8 start while busy ignored

        // Random mix
        for (int i = 0; i < 400; i++) begin
            run_op(1'($urandom), int'($urandom % LIM), 1'($urandom),
                   int'($urandom % LIM), 1'($urandom), ($urandom % 8) == 0);
        end

        // R1 reset mid-result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset mag", int'(res_mag), 0);
        check("R1 re-reset ovf", int'(ovf), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule